// File: doc/BRIEF.md
# Relocatable Interrupt Vector Address Generator

This block forms the program address used to fetch the code of a reset, interrupt or trap vector. A 16-bit processor status register holds a 9-bit vector page pointer in its upper bits. The other seven bits are ordinary read/write control bits. The pointer selects one 128-word page of program space, and that page is the vector table. Each vector owns a slot of four words, which is enough for a delayed branch plus two one-word instructions or one two-word instruction. The fetch address is therefore the pointer, then the 5-bit vector number, then two zero bits.

Software moves the vector table by writing the whole status register in one access. Every later interrupt or trap fetches from the new page. The hardware reset is the exception. It reloads the pointer with all ones, and the block always issues the reset vector fetch at FF80h, whatever the pointer held before. The fetch address leaves the block registered, with a one-cycle valid strobe, one cycle after the request.

Top module: `vec_addr_gen`

## Requirements
- R1: While rst_ni is low, csr_o reads FF80h (pointer bits 15:7 all ones, control bits 6:0 zero) and fetch_valid_o is low.
- R2: On the first clock edge after rst_ni rises, the block issues exactly one reset vector fetch. fetch_valid_o is high for one cycle with fetch_addr_o = FF80h.
- R3: A vec_req_i sampled on a clock edge sets fetch_valid_o high for the following cycle. fetch_addr_o is then {csr_o[15:7], vec_num_i, 2'b00}.
- R4: Vector slots are four words wide. Vector numbers n and n+1 give fetch addresses that differ by 4, and all 32 slots lie inside one 128-word page.
- R5: A csr_we_i sampled on a clock edge loads all 16 bits of csr_wdata_i into the status register, and csr_o shows the new value from the next cycle. Without a write, csr_o holds its value.
- R6: With the pointer written as 5800h, vector 18 (offset 48h) is fetched from 5848h. With the reset pointer it is fetched from FFC8h.
- R7: A hardware reset after the table has been moved restores csr_o to FF80h, and the reset fetch is again at FF80h.
- R8: When a register write and a vector request are sampled on the same edge, the fetch uses the pointer value from before the write.
- R9: fetch_valid_o is low in every cycle that does not follow a sampled request or the reset fetch edge. A request sampled on the reset fetch edge is dropped.
- R10: Control bits 6:0 of the status register have no effect on the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| csr_we_i | input | 1 | Write strobe for the whole status register |
| csr_wdata_i | input | 16 | Write data: pointer in 15:7, control bits in 6:0 |
| vec_req_i | input | 1 | Vector fetch request for an interrupt or trap |
| vec_num_i | input | 5 | Vector number of the request |
| fetch_addr_o | output | 16 | Program address of the vector fetch |
| fetch_valid_o | output | 1 | One-cycle strobe, fetch_addr_o is valid |
| csr_o | output | 16 | Current status register value |

## Verification
A corrupted pointer bit moves whole pages. It shows in fetch_addr_o bits 15:7 on the first request after the corruption, one cycle after that request is sampled, and csr_o shows it at once. A wrong slot computation moves addresses inside the page. The sweeps over all 32 vector numbers on several pointers catch it, because neighbouring vectors must sit 4 apart. A reset fetch that is lost, repeated or routed through the pointer shows in the first two cycles after reset release, and most clearly after the table has been moved away from FF80h.

// File: rtl/vag_pkg.sv
package vag_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned VNUM_W = 5;
  localparam int unsigned SLOT_W = 2;
  localparam int unsigned PTR_W  = ADDR_W - VNUM_W - SLOT_W;
  localparam int unsigned CTL_W  = ADDR_W - PTR_W;

  typedef struct packed {
    logic [PTR_W-1:0] ptr;
    logic [CTL_W-1:0] ctl;
  } csr_t;

  localparam csr_t CSR_RST = '{ptr: '1, ctl: '0};
endpackage

// File: rtl/vag_csr.sv
module vag_csr
  import vag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output csr_t              csr_o
);
  csr_t csr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= CSR_RST;
    else if (we_i) csr_q <= csr_t'(wdata_i);
  end

  assign csr_o = csr_q;
endmodule

// File: rtl/vag_addr.sv
module vag_addr
  import vag_pkg::*;
(
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [VNUM_W-1:0] vnum_i,
  output logic [ADDR_W-1:0] addr_o
);
  generate
    if (SLOT_W == 0) begin : g_noslot
      assign addr_o = {ptr_i, vnum_i};
    end else begin : g_slot
      assign addr_o = {ptr_i, vnum_i, {SLOT_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/vag_out.sv
module vag_out
  import vag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  // reset vector: all-ones page, slot 0, never taken from the pointer
  localparam logic [ADDR_W-1:0] RST_VEC = {{PTR_W{1'b1}}, {(ADDR_W-PTR_W){1'b0}}};

  logic              rst_pend_q;
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pend_q <= 1'b1;
      valid_q    <= 1'b0;
      addr_q     <= RST_VEC;
    end else if (rst_pend_q) begin
      rst_pend_q <= 1'b0;
      valid_q    <= 1'b1;
      addr_q     <= RST_VEC;
    end else begin
      valid_q <= req_i;
      if (req_i) addr_q <= addr_i;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [ADDR_W-1:0] csr_wdata_i,
  input  logic              vec_req_i,
  input  logic [VNUM_W-1:0] vec_num_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_valid_o,
  output logic [ADDR_W-1:0] csr_o
);
  csr_t              csr;
  logic [ADDR_W-1:0] vec_addr;

  vag_csr u_csr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .wdata_i (csr_wdata_i),
    .csr_o   (csr)
  );

  // uses the register value before any same-edge write
  vag_addr u_addr (
    .ptr_i  (csr.ptr),
    .vnum_i (vec_num_i),
    .addr_o (vec_addr)
  );

  vag_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (vec_req_i),
    .addr_i  (vec_addr),
    .addr_o  (fetch_addr_o),
    .valid_o (fetch_valid_o)
  );

  assign csr_o = csr;
endmodule

// File: rtl/vag_chk.sv
module vag_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        csr_we_i,
  input logic [15:0] csr_wdata_i,
  input logic        vec_req_i,
  input logic [4:0]  vec_num_i,
  input logic [15:0] fetch_addr_o,
  input logic        fetch_valid_o,
  input logic [15:0] csr_o
);
  logic up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else up_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (rst_ni && !up_q) AST_RST_CSR: assert (csr_o == 16'hFF80); // R1
  end

  AST_RST_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_q |=> fetch_valid_o && fetch_addr_o == 16'hFF80); // R2

  AST_VEC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q && vec_req_i |=> fetch_valid_o &&
      fetch_addr_o == {$past(csr_o[15:7]), $past(vec_num_i), 2'b00}); // R3

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q && !vec_req_i |=> !fetch_valid_o); // R9

  AST_CSR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i |=> csr_o == $past(csr_wdata_i)); // R5

  AST_CSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q && !csr_we_i |=> $stable(csr_o)); // R5
endmodule

bind vec_addr_gen vag_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_we_i      (csr_we_i),
  .csr_wdata_i   (csr_wdata_i),
  .vec_req_i     (vec_req_i),
  .vec_num_i     (vec_num_i),
  .fetch_addr_o  (fetch_addr_o),
  .fetch_valid_o (fetch_valid_o),
  .csr_o         (csr_o)
);

// File: tb/vec_addr_gen_tb.sv
module vec_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic        vec_req = 1'b0;
  logic [4:0]  vec_num = '0;
  logic [15:0] fetch_addr;
  logic        fetch_valid;
  logic [15:0] csr_rd;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  vec_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
    .vec_req_i(vec_req), .vec_num_i(vec_num), .fetch_addr_o(fetch_addr),
    .fetch_valid_o(fetch_valid), .csr_o(csr_rd));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [15:0] v);
    @(negedge clk); csr_we = 1'b1; csr_wdata = v;
    @(negedge clk); csr_we = 1'b0;
  endtask

  // request at one edge, look at the outputs before the next
  task automatic req_vec(input logic [4:0] n, output logic [15:0] a, output logic v);
    @(negedge clk); vec_req = 1'b1; vec_num = n;
    @(negedge clk); vec_req = 1'b0; a = fetch_addr; v = fetch_valid;
  endtask

  function automatic logic [15:0] exp_addr(input logic [15:0] csr, input logic [4:0] n);
    return 16'((int'(csr) / 128) * 128 + int'(n) * 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] a, prev;
    logic v;
    logic [15:0] ptrs [6];
    ptrs = '{16'h0000, 16'h007F, 16'h5555, 16'hAAAA, 16'hFF00, 16'h2A4B};

    repeat (3) @(negedge clk);
    chk("R1 csr", csr_rd, 16'hFF80);
    chk("R1 valid", fetch_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 valid", fetch_valid, 1);
    chk("R2 addr", fetch_addr, 16'hFF80);
    @(negedge clk);
    chk("R9 idle", fetch_valid, 0);

    // default table, all vectors
    prev = '0;
    for (int n = 0; n < 32; n++) begin
      req_vec(5'(n), a, v);
      chk("R3 valid", v, 1);
      chk("R3 addr", a, exp_addr(16'hFF80, 5'(n)));
      if (n > 0) chk("R4 step", a - prev, 4);
      prev = a;
    end
    @(negedge clk);
    chk("R9 after req", fetch_valid, 0);
    req_vec(5'd18, a, v);
    chk("R6 default int2", a, 16'hFFC8);

    wr_csr(16'h5800);
    chk("R5 readback", csr_rd, 16'h5800);
    repeat (3) @(negedge clk);
    chk("R5 hold", csr_rd, 16'h5800);
    req_vec(5'd18, a, v);
    chk("R6 moved int2", a, 16'h5848);

    // other pages, with control bits varied
    for (int p = 0; p < 6; p++) begin
      wr_csr(ptrs[p]);
      chk("R5 readback", csr_rd, ptrs[p]);
      for (int n = 0; n < 32; n++) begin
        req_vec(5'(n), a, v);
        chk("R10 addr", a, exp_addr(ptrs[p], 5'(n)));
        chk("R4 page", a[15:7], ptrs[p][15:7]);
      end
    end

    // write and request on the same edge
    wr_csr(16'h1280);
    @(negedge clk); csr_we = 1'b1; csr_wdata = 16'h7F00; vec_req = 1'b1; vec_num = 5'd3;
    @(negedge clk); csr_we = 1'b0; vec_req = 1'b0;
    chk("R8 old ptr", fetch_addr, 16'h128C);
    chk("R8 csr", csr_rd, 16'h7F00);
    req_vec(5'd3, a, v);
    chk("R8 new ptr", a, 16'h7F0C);

    // reset again with the table moved, request held across release
    @(negedge clk); rst_n = 1'b0; vec_req = 1'b1; vec_num = 5'd7;
    @(negedge clk);
    chk("R7 csr", csr_rd, 16'hFF80);
    rst_n = 1'b1;
    @(negedge clk); vec_req = 1'b0;
    chk("R7 addr", fetch_addr, 16'hFF80);
    chk("R7 valid", fetch_valid, 1);
    @(negedge clk);
    chk("R9 dropped req", fetch_valid, 0);
    req_vec(5'd7, a, v);
    chk("R3 after reset", a, 16'hFF9C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule